// File: doc/BRIEF.md
# Flash Program/Erase Status Bit Generator

This block produces the status byte that an asynchronous parallel NOR flash returns on its data pins while an internal program or erase is running. It follows the internal operation phase: program, erase timeout window, erase run, erase suspend, program during suspend, protected-block abort and failure hold. It watches the chip-enable and output-enable read strobes and the block address of each read. From these it forms a polling bit, two toggle bits, an error bit and an erase-timer bit. The other three bits are held at zero. When no operation is reported, the pins carry the array data presented at the `arrayData` input.

The command decoder outside this block pulses `progStart` once a program sequence has been accepted (the fourth write) and `eraseStart` once an erase sequence has been accepted (the sixth write). The program and erase engine reports `opDone` or `opFail`. Two cycle counts stand in for the erase start timeout and the abort window that follows when every selected block is protected: `TIMEOUT_CYC` and `ABORT_CYC`.

Bit positions on `dq`: bit 7 is the polling bit, bit 6 the main toggle, bit 5 the error flag, bit 3 the erase timer and bit 2 the block toggle. Bits 4, 1 and 0 are reserved. A read event is a falling edge of `oeN` while `ceN` is low, or a falling edge of `ceN` while `oeN` is low. Both strobes are sampled on `clk`.

Top module: `flash_status_gen`

## Requirements
- R1: After reset and whenever no operation runs, `statusActive` is 0 and `dq` equals `arrayData`.
- R2: While a program runs, `dq[7]` is the inverse of bit 7 of `progData` captured at `progStart`, and `dq[5]` is 0. `opDone` returns the block to R1 behaviour.
- R3: During any program, erase, abort or failure phase, `dq[6]` inverts once per read event. A low `oeN` while `ceN` is high is not a read, and `dq[6]` holds when no read event occurs.
- R4: After `eraseStart`, `dq[3]` is 0 and `dq[7]` is 0 for `TIMEOUT_CYC` cycles. A further `eraseStart` in that window adds its block to the selection and restarts the window. After the window closes, `dq[3]` is 1.
- R5: While an erase runs, `dq[7]` is 0. `dq[2]` inverts on each read of a selected block and reads 1 for any other block. With `chipErase`, every block counts as selected.
- R6: During a program, `dq[2]` and `dq[3]` both read 1.
- R7: After `suspendReq` during an erase run, a read of a selected block gives `dq[7]`=1 and `dq[6]`=1, and `dq[2]` keeps inverting. A read of any other block returns `arrayData` with `statusActive` 0.
- R8: `progStart` during suspend starts a program whose `dq[7]` and `dq[6]` behave as in R2 and R3. Its `opDone` returns to the suspend state of R7.
- R9: `opFail`, or a `progStart` whose `progData` has a 1 where `cellData` has a 0, sets `dq[5]` to 1. The flag holds until `rdReset`, which returns to R1 behaviour.
- R10: After an erase fails, `dq[2]` keeps inverting on reads of the selected blocks and reads 1 elsewhere.
- R11: If all selected blocks are protected in `protMask` when the timeout window ends, `dq[7]` reads 0 and `dq[6]` keeps toggling for `ABORT_CYC` cycles. After that the block returns to R1 behaviour.
- R12: Whenever `statusActive` is 1, `dq[4]`, `dq[1]` and `dq[0]` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| progStart | input | 1 | Program sequence accepted (one-cycle pulse) |
| progData | input | 8 | Byte being programmed |
| cellData | input | 8 | Current content of the target cell |
| eraseStart | input | 1 | Block or chip erase sequence accepted (pulse) |
| eraseBlkSel | input | NUM_BLK | Blocks named by this erase command |
| chipErase | input | 1 | Erase selects all blocks |
| protMask | input | NUM_BLK | Protected blocks |
| suspendReq | input | 1 | Suspend the running erase |
| resumeReq | input | 1 | Resume the suspended erase |
| opDone | input | 1 | Engine finished successfully |
| opFail | input | 1 | Engine reported a failure |
| rdReset | input | 1 | Read/reset command, clears the error state |
| ceN | input | 1 | Chip enable, active low |
| oeN | input | 1 | Output enable, active low |
| rdBlock | input | BLK_W | Block index of the current read address |
| arrayData | input | 8 | Array data for non-status reads |
| dq | output | 8 | Data pins |
| statusActive | output | 1 | `dq` carries status rather than array data |

## Verification
A read event can land in the same cycle as a phase change. Examples are a read on the cycle the timeout window closes, or `opDone` or `opFail` arriving while a read strobe falls. The random part of the bench issues reads to random blocks back to back across the erase window and the erase run, so strobe edges fall on those boundary cycles. Every read is judged against the bench's own record of the last toggle values. Both toggle bits must invert exactly once per read, whichever phase the read lands in, and the polling and timer bits must match the phase the bench expects at the sampling point.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;

  typedef enum logic [2:0] {
    PH_IDLE     = 3'd0,
    PH_PROG     = 3'd1,
    PH_ERS_WAIT = 3'd2,
    PH_ERS_RUN  = 3'd3,
    PH_SUSPEND  = 3'd4,
    PH_SUS_PROG = 3'd5,
    PH_ABORT    = 3'd6,
    PH_ERROR    = 3'd7
  } phase_e;

  typedef struct packed {
    phase_e phase;
    logic   progBit7;
    logic   errIsErase;
  } ctl_t;

  localparam int POLL_BIT = 7;
  localparam int TOG_BIT  = 6;
  localparam int ERR_BIT  = 5;
  localparam int TMR_BIT  = 3;
  localparam int TOG2_BIT = 2;

endpackage

// File: rtl/flash_stat_ctrl.sv
module flash_stat_ctrl
  import flash_stat_pkg::*;
#(
  parameter int NUM_BLK     = 8,
  parameter int TIMEOUT_CYC = 40,
  parameter int ABORT_CYC   = 60
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               progStart,
  input  logic [7:0]         progData,
  input  logic [7:0]         cellData,
  input  logic               eraseStart,
  input  logic [NUM_BLK-1:0] eraseBlkSel,
  input  logic               chipErase,
  input  logic [NUM_BLK-1:0] protMask,
  input  logic               suspendReq,
  input  logic               resumeReq,
  input  logic               opDone,
  input  logic               opFail,
  input  logic               rdReset,
  output ctl_t               ctl,
  output logic [NUM_BLK-1:0] eraseSel
);

  localparam int MAX_CYC = (TIMEOUT_CYC > ABORT_CYC) ? TIMEOUT_CYC : ABORT_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] TMO_LOAD = CNT_W'(TIMEOUT_CYC - 1);
  localparam logic [CNT_W-1:0] ABT_LOAD = CNT_W'(ABORT_CYC - 1);

  phase_e             phase;
  logic [CNT_W-1:0]   cnt;
  logic               progBit7;
  logic               errIsErase;
  logic               overWrite;
  logic [NUM_BLK-1:0] newSel;

  assign overWrite = |(progData & ~cellData);
  assign newSel    = chipErase ? {NUM_BLK{1'b1}} : eraseBlkSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase      <= PH_IDLE;
      cnt        <= '0;
      eraseSel   <= '0;
      progBit7   <= 1'b0;
      errIsErase <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          eraseSel <= '0;
          if (progStart) begin
            progBit7   <= progData[7];
            errIsErase <= 1'b0;
            phase      <= overWrite ? PH_ERROR : PH_PROG;
          end else if (eraseStart) begin
            eraseSel <= newSel;
            cnt      <= TMO_LOAD;
            phase    <= PH_ERS_WAIT;
          end
        end
        PH_PROG, PH_SUS_PROG: begin
          if (opFail) begin
            errIsErase <= 1'b0;
            phase      <= PH_ERROR;
          end else if (opDone) begin
            phase <= (phase == PH_SUS_PROG) ? PH_SUSPEND : PH_IDLE;
          end
        end
        PH_ERS_WAIT: begin
          if (eraseStart) begin
            eraseSel <= eraseSel | newSel;
            cnt      <= TMO_LOAD;
          end else if (cnt == '0) begin
            if ((eraseSel & ~protMask) == '0) begin
              cnt   <= ABT_LOAD;
              phase <= PH_ABORT;
            end else begin
              phase <= PH_ERS_RUN;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_ERS_RUN: begin
          if (opFail) begin
            errIsErase <= 1'b1;
            phase      <= PH_ERROR;
          end else if (opDone) begin
            phase <= PH_IDLE;
          end else if (suspendReq) begin
            phase <= PH_SUSPEND;
          end
        end
        PH_SUSPEND: begin
          if (resumeReq) begin
            phase <= PH_ERS_RUN;
          end else if (progStart) begin
            progBit7   <= progData[7];
            errIsErase <= 1'b0;
            phase      <= overWrite ? PH_ERROR : PH_SUS_PROG;
          end
        end
        PH_ABORT: begin
          if (cnt == '0) phase <= PH_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
        PH_ERROR: begin
          if (rdReset) phase <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign ctl.phase      = phase;
  assign ctl.progBit7   = progBit7;
  assign ctl.errIsErase = errIsErase;

endmodule

// File: rtl/flash_stat_dpath.sv
module flash_stat_dpath
  import flash_stat_pkg::*;
#(
  parameter int NUM_BLK = 8,
  localparam int BLK_W  = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctl_t               ctl,
  input  logic [NUM_BLK-1:0] eraseSel,
  input  logic               ceN,
  input  logic               oeN,
  input  logic [BLK_W-1:0]   rdBlock,
  input  logic [7:0]         arrayData,
  output logic [7:0]         dq,
  output logic               statusActive
);

  logic oePrev, cePrev;
  logic readEvt, inSel, busy, eraseLike;
  logic togMain, togBlk;
  logic blk2;

  assign readEvt = (oePrev & ~oeN & ~ceN) | (cePrev & ~ceN & ~oeN);
  assign inSel   = eraseSel[rdBlock];

  always_comb begin
    busy = 1'b0;
    eraseLike = 1'b0;
    unique case (ctl.phase)
      PH_PROG, PH_SUS_PROG:   busy = 1'b1;
      PH_ERS_WAIT, PH_ERS_RUN,
      PH_ABORT:               begin busy = 1'b1; eraseLike = 1'b1; end
      PH_SUSPEND:             eraseLike = 1'b1;
      PH_ERROR:               begin busy = 1'b1; eraseLike = ctl.errIsErase; end
      default:                ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      oePrev  <= 1'b1;
      cePrev  <= 1'b1;
      togMain <= 1'b0;
      togBlk  <= 1'b0;
    end else begin
      oePrev <= oeN;
      cePrev <= ceN;
      if (readEvt && busy)              togMain <= ~togMain;
      if (readEvt && eraseLike && inSel) togBlk  <= ~togBlk;
    end
  end

  assign blk2 = (eraseLike && inSel) ? togBlk : 1'b1;

  always_comb begin
    dq = 8'h00;
    statusActive = 1'b1;
    unique case (ctl.phase)
      PH_IDLE: begin
        dq = arrayData;
        statusActive = 1'b0;
      end
      PH_PROG, PH_SUS_PROG: begin
        dq[POLL_BIT] = ~ctl.progBit7;
        dq[TOG_BIT]  = togMain;
        dq[TMR_BIT]  = 1'b1;
        dq[TOG2_BIT] = 1'b1;
      end
      PH_ERS_WAIT, PH_ERS_RUN, PH_ABORT: begin
        dq[TOG_BIT]  = togMain;
        dq[TMR_BIT]  = (ctl.phase != PH_ERS_WAIT);
        dq[TOG2_BIT] = blk2;
      end
      PH_SUSPEND: begin
        if (inSel) begin
          dq[POLL_BIT] = 1'b1;
          dq[TOG_BIT]  = 1'b1;
          dq[TMR_BIT]  = 1'b1;
          dq[TOG2_BIT] = blk2;
        end else begin
          dq = arrayData;
          statusActive = 1'b0;
        end
      end
      PH_ERROR: begin
        dq[POLL_BIT] = ctl.errIsErase ? 1'b0 : ~ctl.progBit7;
        dq[TOG_BIT]  = togMain;
        dq[ERR_BIT]  = 1'b1;
        dq[TMR_BIT]  = 1'b1;
        dq[TOG2_BIT] = blk2;
      end
      default: begin
        dq = arrayData;
        statusActive = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import flash_stat_pkg::*;
#(
  parameter int NUM_BLK     = 8,
  parameter int TIMEOUT_CYC = 40,
  parameter int ABORT_CYC   = 60,
  localparam int BLK_W      = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               progStart,
  input  logic [7:0]         progData,
  input  logic [7:0]         cellData,
  input  logic               eraseStart,
  input  logic [NUM_BLK-1:0] eraseBlkSel,
  input  logic               chipErase,
  input  logic [NUM_BLK-1:0] protMask,
  input  logic               suspendReq,
  input  logic               resumeReq,
  input  logic               opDone,
  input  logic               opFail,
  input  logic               rdReset,
  input  logic               ceN,
  input  logic               oeN,
  input  logic [BLK_W-1:0]   rdBlock,
  input  logic [7:0]         arrayData,
  output logic [7:0]         dq,
  output logic               statusActive
);

  ctl_t               ctl;
  logic [NUM_BLK-1:0] eraseSel;

  flash_stat_ctrl #(
    .NUM_BLK(NUM_BLK), .TIMEOUT_CYC(TIMEOUT_CYC), .ABORT_CYC(ABORT_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .progStart(progStart), .progData(progData),
    .cellData(cellData), .eraseStart(eraseStart), .eraseBlkSel(eraseBlkSel),
    .chipErase(chipErase), .protMask(protMask), .suspendReq(suspendReq),
    .resumeReq(resumeReq), .opDone(opDone), .opFail(opFail),
    .rdReset(rdReset), .ctl(ctl), .eraseSel(eraseSel)
  );

  flash_stat_dpath #(.NUM_BLK(NUM_BLK)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .eraseSel(eraseSel),
    .ceN(ceN), .oeN(oeN), .rdBlock(rdBlock), .arrayData(arrayData),
    .dq(dq), .statusActive(statusActive)
  );

endmodule

// File: rtl/flash_status_gen_chk.sv
module flash_status_gen_chk (
  input logic       clk,
  input logic       rstN,
  input logic       rdReset,
  input logic [7:0] arrayData,
  input logic [7:0] dq,
  input logic       statusActive
);

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    statusActive |-> (dq[4] == 1'b0 && dq[1:0] == 2'b00)); // R12

  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rstN)
    !statusActive |-> (dq == arrayData)); // R1

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (statusActive && dq[5] && !rdReset) |=> (statusActive && dq[5])); // R9

  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (statusActive && dq[5] && rdReset) |=> !statusActive); // R9

  AST_TIMER_POLL: assert property (@(posedge clk) disable iff (!rstN)
    (statusActive && !dq[3]) |-> (dq[7] == 1'b0 && dq[5] == 1'b0)); // R4

endmodule

bind flash_status_gen flash_status_gen_chk u_chk (
  .clk(clk), .rstN(rstN), .rdReset(rdReset), .arrayData(arrayData),
  .dq(dq), .statusActive(statusActive)
);

// File: tb/sim_flash_status_gen.sv
module sim_flash_status_gen;

  localparam int CLK_PERIOD = 10;
  localparam int NB   = 8;
  localparam int TMO  = 12;
  localparam int ABT  = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic progStart = 0, eraseStart = 0, chipErase = 0;
  logic suspendReq = 0, resumeReq = 0, opDone = 0, opFail = 0, rdReset = 0;
  logic [7:0] progData = 8'h00, cellData = 8'hFF, arrayData = 8'h5A;
  logic [NB-1:0] eraseBlkSel = '0, protMask = '0;
  logic ceN = 1'b1, oeN = 1'b1;
  logic [2:0] rdBlock = '0;
  logic [7:0] dq;
  logic statusActive;

  int checks = 0;
  int failures = 0;
  logic lastDq6;
  logic lastT2;
  logic lastAct;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_status_gen #(.NUM_BLK(NB), .TIMEOUT_CYC(TMO), .ABORT_CYC(ABT)) u0 (
    .clk(clk), .rstN(rstN), .progStart(progStart), .progData(progData),
    .cellData(cellData), .eraseStart(eraseStart), .eraseBlkSel(eraseBlkSel),
    .chipErase(chipErase), .protMask(protMask), .suspendReq(suspendReq),
    .resumeReq(resumeReq), .opDone(opDone), .opFail(opFail),
    .rdReset(rdReset), .ceN(ceN), .oeN(oeN), .rdBlock(rdBlock),
    .arrayData(arrayData), .dq(dq), .statusActive(statusActive)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expStat(input logic p7, input logic e5,
                                         input logic t3, input logic t2);
    return {p7, 1'b0, e5, 1'b0, t3, t2, 2'b00};
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; cyc(1); s = 1'b0;
  endtask

  task automatic doRead(input logic [2:0] blk, output logic [7:0] v);
    rdBlock = blk; ceN = 1'b0; cyc(1);
    oeN = 1'b0; cyc(1);
    v = dq; lastAct = statusActive;
    oeN = 1'b1; ceN = 1'b1; cyc(1);
  endtask

  initial begin
    cyc(100000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] v, w;
    void'($urandom(32'd4242));
    cyc(3); rstN = 1'b1; cyc(1);

    // R1 reset state
    chk("R1 idle data", dq, arrayData);
    chk("R1 idle active", {7'd0, statusActive}, 8'd0);

    // R2 R6 R12 program
    cellData = 8'hFF; progData = 8'h3C;
    pulse(progStart);
    doRead(3'd0, v);
    chk("R2 R6 R12 program status", v & 8'hBF, expStat(1'b1, 1'b0, 1'b1, 1'b1));
    lastDq6 = v[6];
    doRead(3'd0, v);
    chk("R3 toggle on oe read", {7'd0, v[6]}, {7'd0, ~lastDq6});
    lastDq6 = v[6];
    cyc(5);
    chk("R3 hold without read", {7'd0, dq[6]}, {7'd0, lastDq6});
    oeN = 1'b0; ceN = 1'b1; cyc(2);
    chk("R3 oe low with ce high is no read", {7'd0, dq[6]}, {7'd0, lastDq6});
    ceN = 1'b0; cyc(1);
    chk("R3 toggle on ce read", {7'd0, dq[6]}, {7'd0, ~lastDq6});
    lastDq6 = dq[6];
    oeN = 1'b1; ceN = 1'b1; cyc(1);
    pulse(opDone);
    chk("R2 done returns array", dq, arrayData);
    chk("R2 done inactive", {7'd0, statusActive}, 8'd0);

    // R9 overwrite 1 onto 0
    cellData = 8'h0F; progData = 8'h1F;
    pulse(progStart);
    doRead(3'd1, v);
    chk("R9 overwrite error", v & 8'hBF, expStat(1'b1, 1'b1, 1'b1, 1'b1));
    cyc(6);
    chk("R9 error sticky", {7'd0, dq[5]}, 8'd1);
    pulse(rdReset);
    chk("R9 reset command clears", {7'd0, statusActive}, 8'd0);

    // R9 program failure
    cellData = 8'hFF; progData = 8'h80;
    pulse(progStart);
    pulse(opFail);
    doRead(3'd1, v);
    chk("R9 program fail", v & 8'hBF, expStat(1'b0, 1'b1, 1'b1, 1'b1));
    pulse(rdReset);

    // R4 erase timer with extension
    eraseBlkSel = 8'b0000_0100; protMask = '0;
    pulse(eraseStart);
    doRead(3'd2, v);
    chk("R4 timer low", v & 8'hA8, 8'h00);
    lastT2 = v[2]; lastDq6 = v[6];
    cyc(4);
    eraseBlkSel = 8'b0010_0000;
    pulse(eraseStart);
    cyc(TMO - 5);
    doRead(3'd5, v);
    chk("R4 timer extended", v & 8'hA8, 8'h00);
    chk("R5 block toggle in window", {7'd0, v[2]}, {7'd0, ~lastT2});
    lastT2 = v[2]; lastDq6 = v[6];
    cyc(TMO + 2);
    chk("R4 timer expired", {7'd0, dq[3]}, 8'd1);

    // R5 random reads during erase run
    for (int i = 0; i < 40; i++) begin
      logic [2:0] b;
      logic sel;
      b = 3'($urandom % NB);
      sel = (b == 3'd2) || (b == 3'd5);
      doRead(b, v);
      chk("R5 erase poll/timer", v & 8'hB8, 8'h08);
      chk("R3 erase toggle", {7'd0, v[6]}, {7'd0, ~lastDq6});
      lastDq6 = v[6];
      if (sel) begin
        chk("R5 selected block toggle", {7'd0, v[2]}, {7'd0, ~lastT2});
        lastT2 = v[2];
      end else begin
        chk("R5 unselected block reads 1", {7'd0, v[2]}, 8'd1);
      end
    end

    // R7 suspend
    pulse(suspendReq);
    doRead(3'd2, v);
    chk("R7 suspended block", v & 8'hFF, expStat(1'b1, 1'b0, 1'b1, ~lastT2) | 8'h40);
    lastT2 = v[2];
    doRead(3'd0, v);
    chk("R7 other block data", v, arrayData);
    chk("R7 other block inactive", {7'd0, lastAct}, 8'd0);

    // R8 program while suspended
    cellData = 8'hFF; progData = 8'h00;
    pulse(progStart);
    doRead(3'd0, v);
    chk("R8 suspend program", v & 8'hBF, expStat(1'b1, 1'b0, 1'b1, 1'b1));
    chk("R8 suspend program toggle", {7'd0, v[6]}, {7'd0, ~lastDq6});
    lastDq6 = v[6];
    pulse(opDone);
    doRead(3'd5, v);
    chk("R8 back to suspend", v & 8'hC0, 8'hC0);
    chk("R8 back to suspend toggle2", {7'd0, v[2]}, {7'd0, ~lastT2});
    lastT2 = v[2];

    // resume then fail: R10
    pulse(resumeReq);
    doRead(3'd2, v);
    chk("R5 resumed poll", {7'd0, v[7]}, 8'd0);
    lastT2 = v[2];
    pulse(opFail);
    doRead(3'd5, v);
    chk("R10 failed block toggles", {7'd0, v[2]}, {7'd0, ~lastT2});
    chk("R10 error bit", v & 8'hA0, 8'h20);
    doRead(3'd0, v);
    chk("R10 other block reads 1", {7'd0, v[2]}, 8'd1);
    pulse(rdReset);
    chk("R9 reset after erase fail", dq, arrayData);

    // R5 chip erase
    chipErase = 1'b1; eraseBlkSel = '0;
    pulse(eraseStart);
    chipErase = 1'b0;
    cyc(TMO + 2);
    doRead(3'd7, v);
    doRead(3'd0, w);
    chk("R5 chip erase toggles any block", {7'd0, w[2]}, {7'd0, ~v[2]});
    pulse(opDone);

    // R11 all selected blocks protected
    eraseBlkSel = 8'b0000_0011; protMask = 8'b0000_0111;
    pulse(eraseStart);
    cyc(TMO + 2);
    doRead(3'd4, v);
    chk("R11 abort status", v & 8'hB8, 8'h08);
    doRead(3'd4, w);
    chk("R11 abort toggle", {7'd0, w[6]}, {7'd0, ~v[6]});
    cyc(ABT + 2);
    chk("R11 back to read", {7'd0, statusActive}, 8'd0);
    chk("R11 array data", dq, arrayData);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule